// File: doc/BRIEF.md
# Batch Evaporator Sequence Controller

This block sequences one batch of a concentrating tank. A press of the start button opens the fill valve. Filling continues until the upper level switch trips. The heater then boils off water while the level stays above the mid-level switch and the temperature switch reads cold. When the level sinks below mid-level, the drain valve opens for a fixed number of clock cycles, after which the tank counts as empty. The block then returns to the ready state and lights the lamp again.

The three level and temperature switches arrive with mixed polarity: the two that stop a process are wired so that a broken wire reads as "limit exceeded". The block converts them internally. A fault input shuts every output off and holds the block in that state until reset.

Top module: `evap_batch_ctrl`

## Requirements
- R1: After reset is released, with half_i low, only ready_o is high; fill, drain, heater and agitator outputs are all low.
- R2: A start press is accepted only while ready_o is high and high_n_i is 1 (upper level not reached). A press at any other time leaves fill_o low.
- R3: An accepted start raises fill_o one cycle after the start_i rising edge. fill_o then stays high without start_i held, until the cycle after high_n_i reads 0.
- R4: Switch polarity: high_n_i = 0 means the upper level is exceeded; temp_n_i = 0 means the temperature is at or above the limit; half_i = 1 means the level is above mid.
- R5: heat_o is high only in the heating phase, which begins the cycle after the upper level is reached. Within that phase it equals half_i AND temp_n_i, so it follows the temperature switch combinationally.
- R6: Outside the fault state, agit_o equals half_i in every phase.
- R7: In the heating phase, half_i going low opens the drain one cycle later. drain_o stays high for exactly DRAIN_CYCLES cycles, then ready_o returns.
- R8: ready_o is high only when fill_o, drain_o and half_i are all low.
- R9: Only a rising edge of start_i starts a batch. A start held through the end of a batch does not start another until it is released and pressed again.
- R10: While fault_i is high, all five outputs are low in the same cycle. From the next cycle they stay low whatever the inputs do, until rst_ni is asserted.
- R11: fill_o and drain_o are never high together, and heat_o is never high with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pushbutton, high when pressed |
| high_n_i | input | 1 | Upper level switch, 0 when level exceeded |
| half_i | input | 1 | Mid level switch, 1 when level above mid |
| temp_n_i | input | 1 | Temperature switch, 0 when limit exceeded |
| fault_i | input | 1 | Fault stop, high forces all outputs off |
| fill_o | output | 1 | Fill valve |
| drain_o | output | 1 | Drain valve |
| heat_o | output | 1 | Heater contactor |
| agit_o | output | 1 | Agitator motor |
| ready_o | output | 1 | Done/ready lamp |

## Verification
The assertions assume that the switches are already debounced and synchronous to clk_i, and that fault_i is a clean level. They place no constraint on the physical plausibility of the switch combinations.

The stimulus changes every input only at the falling clock edge, one step at a time. Level changes follow the order of a real tank: up through mid, then the upper level, then down. Implausible combinations are applied only where a requirement asks for them: a start press with the level high, and the sweep of the heating phase over both switches.

// File: rtl/evap_pkg.sv
package evap_pkg;
  typedef enum logic [2:0] {
    ST_READY,
    ST_FILL,
    ST_HEAT,
    ST_DRAIN,
    ST_HALT
  } evap_state_e;

  typedef struct packed {
    logic level_high;
    logic above_half;
    logic hot;
  } evap_sense_t;
endpackage

// File: rtl/evap_sense.sv
module evap_sense
  import evap_pkg::*;
#(
  parameter bit HIGH_ACT_LOW = 1'b1,
  parameter bit HALF_ACT_LOW = 1'b0,
  parameter bit TEMP_ACT_LOW = 1'b1
) (
  input  logic        high_raw_i,
  input  logic        half_raw_i,
  input  logic        temp_raw_i,
  output evap_sense_t sense_o
);
  // fail-safe switches open on limit: a broken wire reads as exceeded
  assign sense_o.level_high = high_raw_i ^ HIGH_ACT_LOW;
  assign sense_o.above_half = half_raw_i ^ HALF_ACT_LOW;
  assign sense_o.hot        = temp_raw_i ^ TEMP_ACT_LOW;
endmodule

// File: rtl/evap_edge.sv
module evap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evap_drain_timer.sv
module evap_drain_timer #(
  parameter int unsigned DRAIN_CYCLES = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DRAIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/evap_seq_fsm.sv
module evap_seq_fsm
  import evap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_rise_i,
  input  evap_sense_t sense_i,
  input  logic        fault_i,
  input  logic        drain_done_i,
  output logic        fill_o,
  output logic        drain_o,
  output logic        heat_o,
  output logic        agit_o,
  output logic        ready_o
);
  evap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_READY: if (start_rise_i && ready_o && !sense_i.level_high) state_d = ST_FILL;
      ST_FILL:  if (sense_i.level_high)  state_d = ST_HEAT;
      ST_HEAT:  if (!sense_i.above_half) state_d = ST_DRAIN;
      ST_DRAIN: if (drain_done_i)        state_d = ST_READY;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
    if (fault_i) state_d = ST_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_READY;
    else         state_q <= state_d;
  end

  logic live;
  assign live    = !fault_i && (state_q != ST_HALT);
  assign fill_o  = live && (state_q == ST_FILL);
  assign drain_o = live && (state_q == ST_DRAIN);
  // temperature switch hysteresis keeps this from chattering
  assign heat_o  = live && (state_q == ST_HEAT) && sense_i.above_half && !sense_i.hot;
  assign agit_o  = live && sense_i.above_half;
  assign ready_o = live && (state_q == ST_READY) && !sense_i.above_half;

  p_fill_seal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o && !sense_i.level_high && !fault_i |=> fill_o || fault_i);
  p_start_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_o) |-> $past(start_rise_i) && $past(ready_o));
  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !fill_o && !drain_o && !heat_o && !agit_o && !ready_o);
  p_heat_after_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o && sense_i.level_high && !fault_i |=> !fill_o && !drain_o);
endmodule

// File: rtl/evap_batch_ctrl.sv
module evap_batch_ctrl
  import evap_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 1_000_000,
  parameter int unsigned DRAIN_S      = 30,
  parameter int unsigned DRAIN_CYCLES = CLK_HZ * DRAIN_S
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic high_n_i,
  input  logic half_i,
  input  logic temp_n_i,
  input  logic fault_i,
  output logic fill_o,
  output logic drain_o,
  output logic heat_o,
  output logic agit_o,
  output logic ready_o
);
  evap_sense_t sense;
  logic        start_rise;
  logic        drain_done;

  evap_sense i_sense (
    .high_raw_i (high_n_i),
    .half_raw_i (half_i),
    .temp_raw_i (temp_n_i),
    .sense_o    (sense)
  );

  evap_edge i_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_i),
    .rise_o (start_rise)
  );

  evap_drain_timer #(.DRAIN_CYCLES(DRAIN_CYCLES)) i_drain_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (drain_o),
    .expired_o (drain_done)
  );

  evap_seq_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_rise_i (start_rise),
    .sense_i      (sense),
    .fault_i      (fault_i),
    .drain_done_i (drain_done),
    .fill_o       (fill_o),
    .drain_o      (drain_o),
    .heat_o       (heat_o),
    .agit_o       (agit_o),
    .ready_o      (ready_o)
  );

  p_fill_drain_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_o && drain_o) && !(heat_o && (fill_o || drain_o)));
  p_heat_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    heat_o |-> half_i && temp_n_i);
  p_lamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !fill_o && !drain_o && !half_i);
  p_agit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i && agit_o |-> half_i);
endmodule

// File: tb/test_evap_batch_ctrl.sv
module test_evap_batch_ctrl;
  localparam int unsigned DC = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, high_n_i = 1'b1, half_i = 1'b0, temp_n_i = 1'b1, fault_i = 1'b0;
  logic fill_o, drain_o, heat_o, agit_o, ready_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evap_batch_ctrl #(.DRAIN_CYCLES(DC)) i_evap_batch_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .high_n_i(high_n_i),
    .half_i(half_i), .temp_n_i(temp_n_i), .fault_i(fault_i),
    .fill_o(fill_o), .drain_o(drain_o), .heat_o(heat_o), .agit_o(agit_o), .ready_o(ready_o)
  );

  // order: fill drain heat agit ready
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    #1;
    act = {fill_o, drain_o, heat_o, agit_o, ready_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 0; high_n_i = 1; half_i = 0; temp_n_i = 1; fault_i = 0;
    step(2);
    rst_ni = 1'b1;
    step();
  endtask

  // run from ready to start of heat phase, start released afterwards
  task automatic to_heat();
    start_i = 1; step(); start_i = 0;
    half_i = 1; step();
    high_n_i = 0; step();
  endtask

  initial begin
    do_reset();
    chk("R1 reset state", 5'b00001);

    // R2: start ignored while lamp dark (level above mid)
    half_i = 1; step();
    chk("R8 lamp off above mid", 5'b00010);
    start_i = 1; step(); start_i = 0; step();
    chk("R2 start ignored lamp dark", 5'b00010);
    // R2: start ignored with upper level reached
    half_i = 0; high_n_i = 0; step();
    chk("R4 upper switch active low, lamp lit", 5'b00001);
    start_i = 1; step(); start_i = 0; step();
    chk("R2 start ignored level high", 5'b00001);
    high_n_i = 1; step();

    // full batch with start held throughout
    start_i = 1; step();
    chk("R3 fill opens", 5'b10000);
    step(3);
    chk("R3 fill sealed", 5'b10000);
    half_i = 1; step();
    chk("R6 agitator during fill, no heat R5", 5'b10010);
    high_n_i = 0; step();
    chk("R5 heat after upper level", 5'b00110);
    temp_n_i = 0;
    chk("R4 R5 hot cuts heater", 5'b00010);
    temp_n_i = 1;
    chk("R5 heater back on", 5'b00110);

    // R5/R6 sweep in heat phase over upper and temperature switches
    for (int v = 0; v < 4; v++) begin
      high_n_i = v[0]; temp_n_i = v[1]; step();
      chk("R5 R6 heat sweep", {2'b00, v[1] ? 1'b1 : 1'b0, 2'b10});
    end
    temp_n_i = 1; high_n_i = 1;

    half_i = 0;
    chk("R5 R6 level below mid", 5'b00000);
    step();
    chk("R7 drain opens", 5'b01000);
    for (int k = 1; k < DC; k++) begin
      step();
      chk("R7 drain held", 5'b01000);
    end
    step();
    chk("R7 ready after drain time", 5'b00001);
    step(3);
    chk("R9 held start no restart", 5'b00001);
    start_i = 0; step();
    start_i = 1; step(); start_i = 0;
    chk("R9 re-press starts", 5'b10000);
    chk("R11 fill alone", 5'b10000);

    // R10: fault in fill phase
    fault_i = 1;
    chk("R10 fault immediate off", 5'b00000);
    step(); fault_i = 0;
    half_i = 1; high_n_i = 0; step();
    chk("R10 halted ignores sensors", 5'b00000);
    half_i = 0; high_n_i = 1; start_i = 1; step(); start_i = 0; step();
    chk("R10 halted ignores start", 5'b00000);
    do_reset();
    chk("R1 R10 reset clears halt", 5'b00001);

    // R10: fault during drain; R7 second batch
    to_heat();
    half_i = 0; step();
    chk("R7 drain second batch", 5'b01000);
    fault_i = 1;
    chk("R10 fault in drain", 5'b00000);
    step(DC + 2); fault_i = 0; step();
    chk("R10 stays halted", 5'b00000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule